// File: doc/BRIEF.md
# Multi-queue shared-SRAM FIFO manager

The block manages a small set of hardware FIFO queues whose 32-bit entries all live in one shared, word-addressed SRAM. Each queue owns a configuration word that places its circular buffer in the SRAM (start in 16-word units, size of 16, 32, 64 or 128 words) and sets two log-encoded watermarks that drive its nearly-empty and nearly-full flags. Software or a neighbouring engine reaches every queue through a per-queue access register: a write pushes one entry and a read pops one.

The register bus has an independent write channel and read channel, so a push and a pop may land in the same cycle, even on the same queue. Read data returns one cycle after the read strobe together with a valid pulse. Per-queue status nibbles are packed eight to a status word, and sticky underflow/overflow flags are packed sixteen queues to a flag word. A pop from an empty queue never stalls: it returns zero and raises the queue's underflow flag. A push to a full queue is dropped and raises the overflow flag.

Bus word addresses: access register of queue q at 0x00+q, configuration word of queue q at 0x10+q, status word k at 0x20+k, flag word k at 0x30+k. Unmapped reads return zero.

Top module: `qbuf_mgr`

## Requirements
- R1: After reset every configuration word reads 0, every flag word reads 0, and every queue's status nibble reads 0x3 (empty and nearly empty set).
- R2: Entries pushed to a queue come back from pops of that queue in push order; read data is presented with rd_valid in the cycle after rd_en.
- R3: Configuration word fields: [3:2] size code (00/01/10/11 = 16/32/64/128 words), [6:4] nearly-empty code, [9:7] nearly-full code (codes 0..7 = thresholds 0,1,2,4,8,16,32,64), [17:10] base in 16-word units, [1:0] entry size reading 00 whatever is written, [24:18] write pointer and [31:25] read pointer (read-only, modulo 128, occupancy = their difference modulo 128). Writing a configuration word clears that queue's pointers, emptying it.
- R4: A queue's status nibble holds bit0 empty, bit1 nearly empty (occupancy <= nearly-empty threshold), bit2 nearly full (free words <= nearly-full threshold), bit3 full; queue q occupies bits 4*(q%8)+3..4*(q%8) of status word q/8.
- R5: A pop from an empty queue returns 0, leaves the pointers unchanged and sets the underflow flag, bit 2*(q%16) of flag word q/16.
- R6: A push to a full queue is dropped, leaving contents and pointers unchanged, and sets the overflow flag, bit 2*(q%16)+1 of flag word q/16.
- R7: Flags are sticky; a write to a flag word clears the flags whose bits are written 0 and leaves those written 1 unchanged; a new event in the same cycle as a clear leaves the flag set.
- R8: Entry slots are addressed as base*16 plus (pointer modulo buffer size), so a queue keeps FIFO order across buffer wrap and across pointer wrap at 128.
- R9: Queues with disjoint SRAM regions are independent: traffic on one queue changes neither the contents, the pointers nor the status of another.
- R10: A push and a pop to the same queue in the same cycle are both accepted, including when the queue is full (the pop returns the oldest entry, occupancy unchanged, no overflow); on an empty queue the pop underflows and returns 0 while the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write channel strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data (pushed entry, configuration or flag-clear mask) |
| rd_en | input | 1 | Read channel strobe |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Pulses in the cycle after rd_en |

## Verification
The push carried by the write channel and the pop carried by the read channel can fall in the same cycle on the same queue. The bench provokes this on a completely full queue, where the write slot equals the slot being read, and on an empty queue, and also lands a flag-clear write in the same cycle as an underflow pop. It judges the outcome through the popped values that follow, the status word, the flag word and the pointer fields of the configuration readback, including a run of 130 paired operations that carries both pointers across the modulo-128 wrap.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;

  localparam int DATA_W = 32;
  localparam int BUS_AW = 6;
  localparam int IDX_W  = 4;
  localparam int PTR_W  = 7;
  localparam int CNT_W  = 8;

  typedef enum logic [1:0] {
    REG_ACC  = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_FLAG = 2'd3
  } region_e;

  typedef struct packed {
    logic [7:0] base;
    logic [2:0] nf_c;
    logic [2:0] ne_c;
    logic [1:0] size_c;
  } qcfg_t;

  function automatic logic [CNT_W-1:0] size_words(input logic [1:0] code);
    return CNT_W'(16) << code;
  endfunction

  function automatic logic [CNT_W-1:0] wm_thresh(input logic [2:0] code);
    if (code == 3'd0) return '0;
    return CNT_W'(1) << (code - 3'd1);
  endfunction

endpackage

// File: rtl/qbuf_sram.sv
module qbuf_sram #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first simple dual port: a same-address write returns old data
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rd <= mem[ra];
  end

endmodule

// File: rtl/qbuf_qctl.sv
module qbuf_qctl
  import qbuf_pkg::*;
#(
  parameter int SRAM_AW = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  qcfg_t              cfg_wdata,
  input  logic               push,
  input  logic               pop,
  input  logic [1:0]         flag_keep,
  output logic               push_ok,
  output logic               pop_ok,
  output logic [SRAM_AW-1:0] wr_slot,
  output logic [SRAM_AW-1:0] rd_slot,
  output logic [3:0]         status,
  output logic [DATA_W-1:0]  cfg_rd,
  output logic               uf,
  output logic               of
);
  localparam int BASE_W = SRAM_AW - 4;

  qcfg_t            cfg_q;
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             uf_q, of_q;

  logic [CNT_W-1:0]   qsize;
  logic [PTR_W-1:0]   slot_mask;
  logic [SRAM_AW-1:0] base_addr;
  logic               is_empty, is_full;

  assign qsize     = size_words(cfg_q.size_c);
  assign slot_mask = PTR_W'(qsize - CNT_W'(1));
  assign base_addr = {cfg_q.base[BASE_W-1:0], 4'b0000};
  assign wr_slot   = base_addr + SRAM_AW'(wp_q & slot_mask);
  assign rd_slot   = base_addr + SRAM_AW'(rp_q & slot_mask);

  assign is_empty = (cnt_q == '0);
  assign is_full  = (cnt_q == qsize);

  assign pop_ok  = pop  & ~cfg_we & ~is_empty;
  assign push_ok = push & ~cfg_we & (~is_full | pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_ok);
      rp_q  <= rp_q + PTR_W'(pop_ok);
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uf_q <= 1'b0;
      of_q <= 1'b0;
    end else begin
      uf_q <= (uf_q & flag_keep[0]) | (pop  & ~cfg_we & is_empty);
      of_q <= (of_q & flag_keep[1]) | (push & ~cfg_we & ~push_ok);
    end
  end

  assign status = {is_full,
                   (qsize - cnt_q) <= wm_thresh(cfg_q.nf_c),
                   cnt_q <= wm_thresh(cfg_q.ne_c),
                   is_empty};
  assign cfg_rd = {rp_q, wp_q, cfg_q.base, cfg_q.nf_c, cfg_q.ne_c, cfg_q.size_c, 2'b00};
  assign uf     = uf_q;
  assign of     = of_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= qsize); // R6
  AST_PTR_OCC: assert property (@(posedge clk) disable iff (rst)
    PTR_W'(wp_q - rp_q) == cnt_q[PTR_W-1:0]); // R3
  AST_UF_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !cfg_we && cnt_q == '0) |=> uf_q); // R5
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (uf_q && flag_keep[0]) |=> uf_q); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop && !cfg_we && cnt_q == qsize) |=> (wp_q == $past(wp_q) && of_q)); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (push_ok && pop_ok) |=> cnt_q == $past(cnt_q)); // R10

endmodule

// File: rtl/qbuf_mgr.sv
module qbuf_mgr
  import qbuf_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int SRAM_AW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int NSW = (NQ + 7) / 8;
  localparam int NFW = (NQ + 15) / 16;

  region_e          wr_reg, rd_reg;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  qcfg_t            cfg_in;

  assign wr_reg = region_e'(wr_addr[BUS_AW-1 -: 2]);
  assign rd_reg = region_e'(rd_addr[BUS_AW-1 -: 2]);
  assign wr_idx = wr_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];
  assign cfg_in = '{base: wr_data[17:10], nf_c: wr_data[9:7],
                    ne_c: wr_data[6:4], size_c: wr_data[3:2]};

  logic [NQ-1:0]      push_v, pop_v, cfgwe_v, push_ok_v, pop_ok_v, uf_v, of_v;
  logic [1:0]         keep_v   [NQ];
  logic [3:0]         status_v [NQ];
  logic [DATA_W-1:0]  cfgrd_v  [NQ];
  logic [SRAM_AW-1:0] wa_v     [NQ];
  logic [SRAM_AW-1:0] ra_v     [NQ];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    localparam int FW_I = g / 16;
    localparam int FB   = 2 * (g % 16);

    assign push_v[g]  = wr_en && wr_reg == REG_ACC && wr_idx == IDX_W'(g);
    assign pop_v[g]   = rd_en && rd_reg == REG_ACC && rd_idx == IDX_W'(g);
    assign cfgwe_v[g] = wr_en && wr_reg == REG_CFG && wr_idx == IDX_W'(g);
    assign keep_v[g]  = (wr_en && wr_reg == REG_FLAG && wr_idx == IDX_W'(FW_I))
                        ? wr_data[FB +: 2] : 2'b11;

    qbuf_qctl #(.SRAM_AW(SRAM_AW)) u_qctl (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfgwe_v[g]),
      .cfg_wdata (cfg_in),
      .push      (push_v[g]),
      .pop       (pop_v[g]),
      .flag_keep (keep_v[g]),
      .push_ok   (push_ok_v[g]),
      .pop_ok    (pop_ok_v[g]),
      .wr_slot   (wa_v[g]),
      .rd_slot   (ra_v[g]),
      .status    (status_v[g]),
      .cfg_rd    (cfgrd_v[g]),
      .uf        (uf_v[g]),
      .of        (of_v[g])
    );
  end

  // shared SRAM ports: at most one queue pushes and one pops per cycle
  logic               sram_we, sram_re;
  logic [SRAM_AW-1:0] sram_wa, sram_ra;
  logic [DATA_W-1:0]  sram_rd;

  always_comb begin
    sram_wa = '0;
    sram_ra = '0;
    for (int q = 0; q < NQ; q++) begin
      if (push_v[q]) sram_wa = wa_v[q];
      if (pop_v[q])  sram_ra = ra_v[q];
    end
  end
  assign sram_we = |push_ok_v;
  assign sram_re = |pop_ok_v;

  qbuf_sram #(.DW(DATA_W), .AW(SRAM_AW)) u_sram (
    .clk (clk),
    .we  (sram_we),
    .wa  (sram_wa),
    .wd  (wr_data),
    .re  (sram_re),
    .ra  (sram_ra),
    .rd  (sram_rd)
  );

  // packed status and flag words
  logic [DATA_W-1:0] stat_w [NSW];
  logic [DATA_W-1:0] flag_w [NFW];

  always_comb begin
    for (int k = 0; k < NSW; k++) stat_w[k] = '0;
    for (int k = 0; k < NFW; k++) flag_w[k] = '0;
    for (int q = 0; q < NQ; q++) begin
      stat_w[q / 8][4 * (q % 8) +: 4]    = status_v[q];
      flag_w[q / 16][2 * (q % 16)]       = uf_v[q];
      flag_w[q / 16][2 * (q % 16) + 1]   = of_v[q];
    end
  end

  logic [DATA_W-1:0] reg_d;
  always_comb begin
    reg_d = '0;
    case (rd_reg)
      REG_CFG:
        for (int q = 0; q < NQ; q++)
          if (rd_idx == IDX_W'(q)) reg_d = cfgrd_v[q];
      REG_STAT:
        for (int k = 0; k < NSW; k++)
          if (rd_idx == IDX_W'(k)) reg_d = stat_w[k];
      REG_FLAG:
        for (int k = 0; k < NFW; k++)
          if (rd_idx == IDX_W'(k)) reg_d = flag_w[k];
      default: reg_d = '0;
    endcase
  end

  logic              rvalid_q, pop_sel_q, pop_hit_q;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q  <= 1'b0;
      pop_sel_q <= 1'b0;
      pop_hit_q <= 1'b0;
      reg_q     <= '0;
    end else begin
      rvalid_q  <= rd_en;
      pop_sel_q <= rd_en && rd_reg == REG_ACC;
      pop_hit_q <= |pop_ok_v;
      reg_q     <= reg_d;
    end
  end

  assign rd_valid = rvalid_q;
  assign rd_data  = pop_sel_q ? (pop_hit_q ? sram_rd : '0) : reg_q;

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R2
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((pop_v & ~pop_ok_v) != '0) |=> rd_data == '0); // R5
  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_ok_v)); // R9

endmodule

// File: tb/qbuf_mgr_tb_top.sv
module qbuf_mgr_tb_top;
  localparam int CLK_P = 10;

  localparam logic [5:0] ACC  = 6'h00;
  localparam logic [5:0] CFG  = 6'h10;
  localparam logic [5:0] STAT = 6'h20;
  localparam logic [5:0] FLG  = 6'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_v [$];
  string       exp_t [$];

  always #(CLK_P/2) clk = ~clk;

  qbuf_mgr dut_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [31:0] mk_cfg(input int sz, input int ne, input int nf, input int base);
    return (32'(base) << 10) | (32'(nf) << 7) | (32'(ne) << 4) | (32'(sz) << 2);
  endfunction

  // monitor: compares every returned read against the scoreboard
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_v.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: got %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_t.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic op(input logic we, input logic [5:0] wa, input logic [31:0] wd,
                    input logic re, input logic [5:0] ra, input logic [31:0] ev,
                    input string tag);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re) begin
      exp_v.push_back(ev);
      exp_t.push_back(tag);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    op(1'b1, a, d, 1'b0, 6'h0, 32'h0, "");
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    op(1'b0, 6'h0, 32'h0, 1'b1, a, e, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(STAT, 32'h0000_3333, "R1 status after reset");
    rd(CFG,  32'h0,         "R1 cfg q0 after reset");
    rd(CFG+3, 32'h0,        "R1 cfg q3 after reset");
    rd(FLG,  32'h0,         "R1 flags after reset");

    // R3 configure q0: 16 words, thresholds 2/2, base 0
    wr(CFG, mk_cfg(0, 2, 2, 0));
    rd(CFG, 32'h0000_0120, "R3 cfg readback");
    for (int i = 0; i < 3; i++) wr(ACC, 32'hA000_0000 + i);
    rd(STAT, 32'h0000_3330, "R4 q0 three entries");
    rd(CFG, 32'h000C_0120, "R3 write pointer field");
    for (int i = 0; i < 3; i++) rd(ACC, 32'hA000_0000 + i, "R2 fifo order");

    // R5 underflow
    rd(ACC, 32'h0, "R5 empty pop returns zero");
    rd(FLG, 32'h1, "R5 underflow flag");
    rd(CFG, 32'h060C_0120, "R5 pointers unchanged");

    // R7 sticky and clear rules
    wr(FLG, 32'hFFFF_FFFF);
    rd(FLG, 32'h1, "R7 written one keeps flag");
    wr(FLG, 32'hFFFF_FFFE);
    rd(FLG, 32'h0, "R7 written zero clears");
    op(1'b1, FLG, 32'hFFFF_FFFE, 1'b1, ACC, 32'h0, "R7 pop during clear");
    rd(FLG, 32'h1, "R7 event beats clear");
    wr(FLG, 32'h0);

    // R4 watermark boundaries, R6 overflow, R8 buffer wrap
    for (int i = 0; i < 13; i++) wr(ACC, 32'hB000_0000 + i);
    rd(STAT, 32'h0000_3330, "R4 free 3 not nearly full");
    wr(ACC, 32'hB000_000D);
    rd(STAT, 32'h0000_3334, "R4 free 2 nearly full");
    wr(ACC, 32'hB000_000E);
    wr(ACC, 32'hB000_000F);
    rd(STAT, 32'h0000_333C, "R4 full");
    wr(ACC, 32'h0000_DEAD);
    rd(FLG, 32'h2, "R6 overflow flag");
    rd(STAT, 32'h0000_333C, "R6 still full");
    for (int i = 0; i < 14; i++) rd(ACC, 32'hB000_0000 + i, "R8 order across wrap");
    rd(STAT, 32'h0000_3332, "R4 two left nearly empty");
    rd(ACC, 32'hB000_000E, "R8 order across wrap");
    rd(ACC, 32'hB000_000F, "R6 last kept entry");
    rd(ACC, 32'h0, "R6 dropped entry absent");
    wr(FLG, 32'h0);
    rd(FLG, 32'h0, "R7 cleared");

    // R10 simultaneous push and pop on a full 32-word queue
    wr(CFG+1, mk_cfg(1, 0, 0, 2));
    for (int i = 0; i < 32; i++) wr(ACC+1, 32'hC000_0000 + i);
    rd(STAT, 32'h0000_33C3, "R4 q1 full");
    op(1'b1, ACC+1, 32'hE1E1_E1E1, 1'b1, ACC+1, 32'hC000_0000, "R10 pop at full");
    rd(STAT, 32'h0000_33C3, "R10 occupancy held");
    rd(FLG, 32'h0, "R10 no overflow");
    for (int i = 1; i < 32; i++) rd(ACC+1, 32'hC000_0000 + i, "R10 drain order");
    rd(ACC+1, 32'hE1E1_E1E1, "R10 paired push stored");
    rd(STAT, 32'h0000_3333, "R4 all empty");
    op(1'b1, ACC+1, 32'hF1F1_F1F1, 1'b1, ACC+1, 32'h0, "R10 pop on empty");
    rd(FLG, 32'h4, "R10 empty pair underflows");
    rd(ACC+1, 32'hF1F1_F1F1, "R10 empty pair push stored");
    wr(FLG, 32'h0);

    // R3 entry size read-only, R9 isolation
    wr(CFG+2, mk_cfg(0, 0, 0, 4));
    wr(CFG+3, mk_cfg(0, 0, 0, 6) | 32'h3);
    rd(CFG+3, 32'h0000_1800, "R3 entry size reads 00");
    wr(ACC+2, 32'hD000_0000);
    wr(ACC+3, 32'hEE00_0000);
    wr(ACC+2, 32'hD000_0001);
    rd(STAT, 32'h0000_0033, "R9 per-queue status");
    rd(ACC+3, 32'hEE00_0000, "R9 q3 content");
    rd(ACC+2, 32'hD000_0000, "R9 q2 content");
    rd(ACC+2, 32'hD000_0001, "R9 q2 content");
    rd(CFG, 32'h264C_0120, "R9 q0 pointers untouched");

    // R8 pointer wrap at 128 through paired operations
    wr(ACC+2, 32'h5000_0000);
    for (int i = 0; i < 130; i++)
      op(1'b1, ACC+2, 32'h5000_0001 + i, 1'b1, ACC+2, 32'h5000_0000 + i, "R8 paired stream");
    rd(CFG+2, 32'h0814_1000, "R8 pointers modulo 128");
    rd(ACC+2, 32'h5000_0082, "R8 last entry");

    // R3 config write empties the queue
    wr(ACC+2, 32'h7777_7777);
    wr(CFG+2, mk_cfg(0, 0, 0, 4));
    rd(CFG+2, 32'h0000_1000, "R3 config clears pointers");
    rd(STAT, 32'h0000_3333, "R3 queue empty after config");
    rd(ACC+2, 32'h0, "R3 old entry gone");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_v.size() != 0) begin
      errors++;
      $display("FAIL R2 missing read data: got %0d pending expected 0", exp_v.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule